// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps a sixteen-slot circular record of dispatched instructions so that they leave the machine in the order they entered it, although their execution finishes in any order. Dispatch writes up to two new entries per cycle at the tail. Each entry holds a tag, a class, a ready flag and the cycle number at which it retired. Completion reports name an entry by its slot index. Each report arrives on a port that matches the stage finishing that class: result-bus ports for loads and ALU operations, a memory-done port for stores, and a branch-done port for conditional branches.

A report in one cycle sets the entry's ready flag at the following clock edge. The retire check reads only the ready flags that are already registered. When the oldest entry is ready, the block raises the commit strobe for one cycle, presents that entry's tag and the current cycle number, and advances the head pointer. Dispatch reads the tail pointer to learn which slot indices its instructions received. It must stall while the full flag is high.

Top module: `retire_queue`

## Requirements
- R1: Entries retire strictly in allocation order. Only the entry at the head pointer may retire, and a ready entry behind a not-ready head waits.
- R2: At most one entry retires per cycle. A run of ready entries retires on consecutive cycles, one per cycle, and `commit_tag` carries the head entry's tag.
- R3: A completion report presented during cycle t cannot raise `commit_valid` in cycle t. If the reported entry is at the head, it retires in cycle t+1.
- R4: An entry whose class is neither 2'b01 nor 2'b10 (an ALU operation or a load) becomes ready only through result-bus port 0 or 1. A report for it on the memory-done or branch-done port is ignored.
- R5: An entry of class 2'b01 (store) becomes ready only through the memory-done port. A result-bus report for it is ignored.
- R6: An entry of class 2'b10 (conditional branch) becomes ready only through the branch-done port. A result-bus report for it is ignored.
- R7: `commit_cycle` equals the number of rising clock edges since reset was released. The value at retirement is stored in the retiring slot and read back on `stamp_value` for the slot selected by `stamp_idx`.
- R8: `full` is high when fewer than two slots are free. Allocation requests made while `full` is high are ignored and leave `tail_ptr` unchanged.
- R9: A report naming a slot that is not allocated is ignored. The slot is not ready when it is later allocated.
- R10: Synchronous active-high reset empties the queue. After reset, `empty` is 1, `full` is 0, both pointers are 0 and `commit_valid` is 0.
- R11: When both dispatch lanes are accepted, lane 0 takes the slot at `tail_ptr` and lane 1 the next slot. A lone lane-1 request takes the slot at `tail_ptr`. `tail_ptr` advances by the number of accepted lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc0_valid | input | 1 | Dispatch lane 0 request |
| alloc0_tag | input | TAG_W | Lane 0 instruction tag |
| alloc0_class | input | 2 | Lane 0 class (01 store, 10 branch, other ALU/load) |
| alloc1_valid | input | 1 | Dispatch lane 1 request |
| alloc1_tag | input | TAG_W | Lane 1 instruction tag |
| alloc1_class | input | 2 | Lane 1 class |
| rb0_valid | input | 1 | Result-bus 0 report |
| rb0_idx | input | IDX_W | Slot reported on result bus 0 |
| rb1_valid | input | 1 | Result-bus 1 report |
| rb1_idx | input | IDX_W | Slot reported on result bus 1 |
| mem_valid | input | 1 | Store memory access finished |
| mem_idx | input | IDX_W | Slot of the finished store |
| br_valid | input | 1 | Branch execution finished |
| br_idx | input | IDX_W | Slot of the finished branch |
| stamp_idx | input | IDX_W | Slot whose retire cycle is read |
| stamp_value | output | STAMP_W | Retire cycle stored for `stamp_idx` |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring entry |
| commit_cycle | output | STAMP_W | Current cycle number |
| head_ptr | output | IDX_W | Oldest slot |
| tail_ptr | output | IDX_W | Next slot to allocate |
| full | output | 1 | Fewer than two slots free |
| empty | output | 1 | No entries held |

## Verification
A corrupted ready flag or class field shows up at the ports as a commit that comes early, late or never, seen on the first cycle the affected slot sits at the head. A wrong head or tail pointer reorders `commit_tag` against the dispatch order on the very next retirement. A wrong occupancy count flips `full` or `empty` within one allocation of the boundary. The scoreboard pairs every retirement with the tag and slot it expects, so any of these faults is caught on the cycle it first becomes visible.

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 8,
  parameter int STAMP_W = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc0_valid,
  input  logic [TAG_W-1:0]   alloc0_tag,
  input  logic [1:0]         alloc0_class,
  input  logic               alloc1_valid,
  input  logic [TAG_W-1:0]   alloc1_tag,
  input  logic [1:0]         alloc1_class,
  input  logic               rb0_valid,
  input  logic [IDX_W-1:0]   rb0_idx,
  input  logic               rb1_valid,
  input  logic [IDX_W-1:0]   rb1_idx,
  input  logic               mem_valid,
  input  logic [IDX_W-1:0]   mem_idx,
  input  logic               br_valid,
  input  logic [IDX_W-1:0]   br_idx,
  input  logic [IDX_W-1:0]   stamp_idx,
  output logic [STAMP_W-1:0] stamp_value,
  output logic               commit_valid,
  output logic [TAG_W-1:0]   commit_tag,
  output logic [STAMP_W-1:0] commit_cycle,
  output logic [IDX_W-1:0]   head_ptr,
  output logic [IDX_W-1:0]   tail_ptr,
  output logic               full,
  output logic               empty
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [1:0] CLS_STORE  = 2'b01;
  localparam logic [1:0] CLS_BRANCH = 2'b10;

  logic [TAG_W-1:0]   tag_q   [DEPTH];
  logic [1:0]         cls_q   [DEPTH];
  logic [STAMP_W-1:0] stamp_q [DEPTH];
  logic [DEPTH-1:0]   busy_q, rdy_q, done;
  logic [CNT_W-1:0]   count_q;
  logic [STAMP_W-1:0] cyc_q;
  logic               acc0, acc1;
  logic [IDX_W-1:0]   slot1;

  assign acc0         = alloc0_valid && !full;
  assign acc1         = alloc1_valid && !full;
  assign slot1        = tail_ptr + IDX_W'(acc0);
  assign full         = count_q >= CNT_W'(DEPTH - 1);
  assign empty        = count_q == '0;
  assign commit_valid = busy_q[head_ptr] && rdy_q[head_ptr];
  assign commit_tag   = tag_q[head_ptr];
  assign commit_cycle = cyc_q;
  assign stamp_value  = stamp_q[stamp_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_rb, hit_mem, hit_br;
    assign hit_rb  = (rb0_valid && rb0_idx == IDX_W'(i)) || (rb1_valid && rb1_idx == IDX_W'(i));
    assign hit_mem = mem_valid && mem_idx == IDX_W'(i);
    assign hit_br  = br_valid && br_idx == IDX_W'(i);
    assign done[i] = busy_q[i] && !rdy_q[i] &&
                     (cls_q[i] == CLS_STORE  ? hit_mem :
                      cls_q[i] == CLS_BRANCH ? hit_br  : hit_rb);

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q[i]  <= 1'b0;
        rdy_q[i]   <= 1'b0;
        tag_q[i]   <= '0;
        cls_q[i]   <= '0;
        stamp_q[i] <= '0;
      end else begin
        if (commit_valid && head_ptr == IDX_W'(i)) begin
          busy_q[i]  <= 1'b0;
          rdy_q[i]   <= 1'b0;
          stamp_q[i] <= cyc_q;
        end
        if (done[i]) rdy_q[i] <= 1'b1;
        if (acc0 && tail_ptr == IDX_W'(i)) begin
          busy_q[i] <= 1'b1;
          rdy_q[i]  <= 1'b0;
          tag_q[i]  <= alloc0_tag;
          cls_q[i]  <= alloc0_class;
        end else if (acc1 && slot1 == IDX_W'(i)) begin
          busy_q[i] <= 1'b1;
          rdy_q[i]  <= 1'b0;
          tag_q[i]  <= alloc1_tag;
          cls_q[i]  <= alloc1_class;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count_q  <= '0;
      cyc_q    <= '0;
    end else begin
      head_ptr <= head_ptr + IDX_W'(commit_valid);
      tail_ptr <= tail_ptr + IDX_W'(acc0) + IDX_W'(acc1);
      count_q  <= count_q + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(commit_valid);
      cyc_q    <= cyc_q + 1'b1;
    end
  end

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> head_ptr == $past(head_ptr) + IDX_W'(1)); // R1
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit_valid |=> $stable(head_ptr)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH)); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    full |=> tail_ptr == $past(tail_ptr)); // R8
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> commit_cycle == $past(commit_cycle) + STAMP_W'(1)); // R7
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> empty && !commit_valid && head_ptr == '0 && tail_ptr == '0); // R10
endmodule

// File: tb/test_retire_queue.sv
module test_retire_queue;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;

  logic clk = 0, rst = 1;
  logic alloc0_valid = 0, alloc1_valid = 0;
  logic [7:0] alloc0_tag = 0, alloc1_tag = 0;
  logic [1:0] alloc0_class = 0, alloc1_class = 0;
  logic rb0_valid = 0, rb1_valid = 0, mem_valid = 0, br_valid = 0;
  logic [IDX_W-1:0] rb0_idx = 0, rb1_idx = 0, mem_idx = 0, br_idx = 0, stamp_idx = 0;
  logic [15:0] stamp_value, commit_cycle;
  logic commit_valid, full, empty;
  logic [7:0] commit_tag;
  logic [IDX_W-1:0] head_ptr, tail_ptr;

  int checks = 0, errors = 0;
  logic [15:0] tb_cyc;
  logic [15:0] seen_stamp [16];
  logic [11:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  retire_queue i_retire_queue (.*);

  always @(posedge clk) tb_cyc <= rst ? 16'd0 : tb_cyc + 16'd1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic done_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops expected {slot, tag} in program order
  always @(negedge clk) begin
    if (!rst && commit_valid) begin
      if (expq.size() == 0) chk("R1 unexpected commit", {20'd0, head_ptr, commit_tag}, 32'hFFF);
      else begin
        logic [11:0] e;
        e = expq.pop_front();
        chk("R1 commit order slot/tag", {20'd0, head_ptr, commit_tag}, {20'd0, e});
        chk("R7 commit cycle", commit_cycle, tb_cyc);
        seen_stamp[head_ptr] = commit_cycle;
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
    alloc0_valid = 0; alloc1_valid = 0;
    rb0_valid = 0; rb1_valid = 0; mem_valid = 0; br_valid = 0;
  endtask

  task automatic alloc(bit v0, logic [7:0] t0, logic [1:0] c0,
                       bit v1, logic [7:0] t1, logic [1:0] c1, bit accept);
    logic [IDX_W-1:0] s;
    s = tail_ptr;
    alloc0_valid = v0; alloc0_tag = t0; alloc0_class = c0;
    alloc1_valid = v1; alloc1_tag = t1; alloc1_class = c1;
    if (accept) begin
      if (v0) begin expq.push_back({s, t0}); s = s + 1'b1; end
      if (v1) expq.push_back({s, t1});
    end
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    chk("R10 empty", empty, 1); chk("R10 full", full, 0);
    chk("R10 head", head_ptr, 0); chk("R10 tail", tail_ptr, 0);
    chk("R10 commit", commit_valid, 0);

    alloc(1, 8'h10, 2'b00, 1, 8'h11, 2'b01, 1);
    chk("R11 tail after pair", tail_ptr, 2);
    alloc(0, 8'h00, 2'b00, 1, 8'h12, 2'b10, 1);
    chk("R11 tail after lane1 only", tail_ptr, 3);

    rb0_valid = 1; rb0_idx = 1; rb1_valid = 1; rb1_idx = 2; br_valid = 1; br_idx = 0;
    step(); step(); step();
    chk("R4 alu ignores branch port", commit_valid, 0);
    chk("R1 head held", head_ptr, 0);

    rb0_valid = 1; rb0_idx = 0; #1;
    chk("R3 no same-cycle commit", commit_valid, 0);
    @(negedge clk);
    chk("R3 commit next cycle", commit_valid, 1);
    chk("R2 tag at head", commit_tag, 8'h10);
    #1 rb0_valid = 0;
    step();
    chk("R5 store ignores result bus", commit_valid, 0);
    mem_valid = 1; mem_idx = 1; step(); step();
    chk("R6 branch ignores result bus", commit_valid, 0);
    br_valid = 1; br_idx = 2; step(); step();
    chk("R1 empty after three", empty, 1);

    rb0_valid = 1; rb0_idx = 3; step();
    alloc(1, 8'h20, 2'b00, 0, 8'h00, 2'b00, 1);
    step(); step(); step();
    chk("R9 stale report ignored", commit_valid, 0);
    rb1_valid = 1; rb1_idx = 3; step(); step();
    stamp_idx = 3; #1;
    chk("R7 stored stamp", stamp_value, seen_stamp[3]);

    for (int k = 0; k < 7; k++) alloc(1, 8'h30 + 8'(2*k), 2'b00, 1, 8'h31 + 8'(2*k), 2'b00, 1);
    chk("R8 not full at 14", full, 0);
    alloc(1, 8'h50, 2'b00, 0, 8'h00, 2'b00, 1);
    chk("R8 full at 15", full, 1);
    alloc(1, 8'h60, 2'b00, 1, 8'h61, 2'b00, 0);
    chk("R8 tail unchanged when full", tail_ptr, 3);
    chk("R8 still full", full, 1);

    for (int p = 14; p >= 2; p -= 2) begin
      rb0_valid = 1; rb0_idx = 4'(4 + p);
      rb1_valid = 1; rb1_idx = 4'(4 + p - 1);
      step();
    end
    chk("R1 head blocks younger", commit_valid, 0);
    rb0_valid = 1; rb0_idx = 4;
    step();
    for (int i = 0; i < 15; i++) begin
      chk("R2 one per cycle", commit_valid, 1);
      @(negedge clk); #1;
    end
    chk("R2 stream ended", commit_valid, 0);
    chk("R1 empty after drain", empty, 1);
    chk("R1 head after drain", head_ptr, 3);
    chk("R1 scoreboard drained", expq.size(), 0);
    done_run();
  end
endmodule